// File: doc/BRIEF.md
# Programmable CRC Engine with Register Access

This block computes a cyclic redundancy check over data that software writes into it through a small word-addressed register interface. The generator polynomial, the CRC width (32, 16, 8 or 7 bits), the starting value and the bit ordering of both the incoming data and the returned result can all be programmed. A data write absorbs 8, 16 or 32 bits, depending on its byte-lane strobes. The whole update happens in the clock edge that accepts the write. Reading the data register returns the running result at any time.

Software starts a computation by setting a self-clearing reload bit in the control register. That bit copies the initial-value register into the CRC. Data writes that follow without a reload continue from the previous result. With default settings the engine produces the MSB-first CRC-32 that has no final inversion. With per-byte input reversal and output reversal enabled, software only has to invert the result to obtain the common reflected CRC-32.

A two-state controller sequences the reload. `ST_RUN` is the normal state: each data write advances the CRC, and idle cycles hold it. The transition `reload_request` moves from `ST_RUN` to `ST_RELOAD` when the control register is written with the reload bit set. During `ST_RELOAD` the CRC base is the initial value masked to the active width. A data write in that cycle starts from this base. The transition `reload_done` returns to `ST_RUN` on the next edge, unless a new reload request arrives in that cycle.

Top module: `crc_calc_unit`

## Requirements
- R1: After reset the initial-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: A write to word 0 (data) with strobes 0001 absorbs bits 7:0, with 0011 bits 15:0, and with 1111 all 32 bits. Within the written unit, bits enter MSB first, so byte, half-word and word writes of the same byte stream give the same CRC.
- R3: With control fields at 0 and the default polynomial and initial value, the string "123456789" gives 0x0376E6E7.
- R4: With input mode per-byte, output reversal on and the defaults, the inverted result for "123456789" is 0xCBF43926, and for a single byte 0x00 it is 0xD202EF8D.
- R5: Writing word 1 (control) with strobe bit 0 set and bit 5 set reloads the CRC from the initial value (masked to the width) on the next edge. A data write in the cycle right after the control write starts from that reloaded value. The reload bit reads back as 0.
- R6: Without a reload, data writes continue from the current result, and idle cycles leave the result unchanged.
- R7: Control bits 1:0 select the width: 00 = 32, 01 = 16, 10 = 8, 11 = 7. For "123456789": polynomial 0x1021 with initial value 0xFFFF gives 0x29B1; 0x07 with initial value 0 gives 0xF4; 0x09 with initial value 0 gives 0x75.
- R8: Control bits 3:2 select input reversal: 00 none, 01 within each byte, 10 within each half-word, 11 across the whole word. A span wider than the access is clamped to the access width.
- R9: Control bit 4 reverses the bit order of the result over the active width and is independent of input reversal. With input mode 00 and the R3 data, the result is 0xE7676EC0.
- R10: The initial-value (word 2) and polynomial (word 3) registers are written byte lane by byte lane under the strobes, and only the low bits that fit the selected width take effect.
- R11: A data write with any strobe pattern other than 0001, 0011 or 1111 leaves the CRC unchanged.
- R12: The control register reads back bits 4:0 as written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word index: 0 data, 1 control, 2 initial value, 3 polynomial |
| bus_be | input | 4 | Byte-lane strobes of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |

## Verification
A corrupt CRC register is visible on the data read port in the same cycle that follows the faulty edge. A corrupt reload sequence is visible within one cycle, because the data register must show the masked initial value immediately after the reload edge. The bench holds the address on the data register whenever it is not reading configuration, and it compares the port against a bit-serial reference every clock. A wrong width, reversal span or strobe decode therefore shows up on the first write that uses it. Known check values for each width and ordering confirm that the reference itself matches the standard algorithms.

// File: rtl/crc_unit_pkg.sv
`timescale 1ns/1ps
package crc_unit_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int CNT_W  = $clog2(WORD_W) + 1;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SZ_32 = 2'b00,
        SZ_16 = 2'b01,
        SZ_8  = 2'b10,
        SZ_7  = 2'b11
    } poly_size_e;

    typedef enum logic [1:0] {
        RV_NONE = 2'b00,
        RV_BYTE = 2'b01,
        RV_HALF = 2'b10,
        RV_WORD = 2'b11
    } in_rev_e;

    typedef enum logic [1:0] {
        RG_DATA = 2'b00,
        RG_CTRL = 2'b01,
        RG_INIT = 2'b10,
        RG_POLY = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        AW_NONE,
        AW_BYTE,
        AW_HALF,
        AW_WORD
    } access_w_e;

    typedef enum logic {
        ST_RUN,
        ST_RELOAD
    } ctl_state_e;

    typedef struct packed {
        logic       out_rev;
        in_rev_e    in_rev;
        poly_size_e size;
    } crc_cfg_t;

    localparam int CFG_W = $bits(crc_cfg_t);

    function automatic logic [CNT_W-1:0] size_bits(input poly_size_e s);
        logic [CNT_W-1:0] n;
        unique case (s)
            SZ_32: n = CNT_W'(32);
            SZ_16: n = CNT_W'(16);
            SZ_8:  n = CNT_W'(8);
            SZ_7:  n = CNT_W'(7);
        endcase
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(input poly_size_e s);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (CNT_W'(i) < size_bits(s)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_reg_bank.sv
`timescale 1ns/1ps
module crc_reg_bank
    import crc_unit_pkg::*;
#(
    parameter logic [WORD_W-1:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [WORD_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  reg_sel_e          reg_sel,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] result,
    output crc_cfg_t          cfg_q,
    output logic [WORD_W-1:0] init_q,
    output logic [WORD_W-1:0] poly_q,
    output logic              reload_req,
    output access_w_e         data_aw,
    output logic [WORD_W-1:0] rdata
);

    localparam int RELOAD_BIT = CFG_W;

    logic wr_hit;
    assign wr_hit = bus_sel && bus_wr;

    assign reload_req = wr_hit && (reg_sel == RG_CTRL) && bus_be[0] && bus_wdata[RELOAD_BIT];

    always_comb begin
        data_aw = AW_NONE;
        if (wr_hit && (reg_sel == RG_DATA)) begin
            unique case (bus_be)
                4'b0001: data_aw = AW_BYTE;
                4'b0011: data_aw = AW_HALF;
                4'b1111: data_aw = AW_WORD;
                default: data_aw = AW_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_hit && (reg_sel == RG_CTRL) && bus_be[0]) begin
            cfg_q <= crc_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= INIT_RST;
            poly_q <= POLY_RST;
        end else if (wr_hit) begin
            for (int l = 0; l < LANES; l++) begin
                if (bus_be[l] && (reg_sel == RG_INIT)) init_q[8*l +: 8] <= bus_wdata[8*l +: 8];
                if (bus_be[l] && (reg_sel == RG_POLY)) poly_q[8*l +: 8] <= bus_wdata[8*l +: 8];
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            RG_DATA: rdata = result;
            RG_CTRL: rdata = {{(WORD_W-CFG_W){1'b0}}, cfg_q};
            RG_INIT: rdata = init_q;
            RG_POLY: rdata = poly_q;
        endcase
    end

endmodule

// File: rtl/crc_in_shaper.sv
`timescale 1ns/1ps
module crc_in_shaper
    import crc_unit_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  access_w_e         aw,
    input  in_rev_e           mode,
    output logic [WORD_W-1:0] feed,
    output logic [CNT_W-1:0]  feed_bits
);

    logic [WORD_W-1:0] rv_byte;
    logic [WORD_W-1:0] rv_half;
    logic [WORD_W-1:0] rv_word;
    logic [WORD_W-1:0] picked;
    in_rev_e           eff;

    for (genvar u = 0; u < LANES; u++) begin : g_byte
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign rv_byte[8*u+j] = din[8*u+7-j];
        end
    end

    for (genvar u = 0; u < LANES/2; u++) begin : g_half
        for (genvar j = 0; j < 16; j++) begin : g_bit
            assign rv_half[16*u+j] = din[16*u+15-j];
        end
    end

    for (genvar j = 0; j < WORD_W; j++) begin : g_word
        assign rv_word[j] = din[WORD_W-1-j];
    end

    always_comb begin
        eff = mode;
        unique case (aw)
            AW_BYTE: if (mode == RV_HALF || mode == RV_WORD) eff = RV_BYTE;
            AW_HALF: if (mode == RV_WORD) eff = RV_HALF;
            AW_WORD, AW_NONE: eff = mode;
        endcase

        unique case (eff)
            RV_NONE: picked = din;
            RV_BYTE: picked = rv_byte;
            RV_HALF: picked = rv_half;
            RV_WORD: picked = rv_word;
        endcase

        unique case (aw)
            AW_NONE: begin
                feed      = '0;
                feed_bits = '0;
            end
            AW_BYTE: begin
                feed      = {picked[7:0], {(WORD_W-8){1'b0}}};
                feed_bits = CNT_W'(8);
            end
            AW_HALF: begin
                feed      = {picked[15:0], {(WORD_W-16){1'b0}}};
                feed_bits = CNT_W'(16);
            end
            AW_WORD: begin
                feed      = picked;
                feed_bits = CNT_W'(WORD_W);
            end
        endcase
    end

endmodule

// File: rtl/crc_step_engine.sv
`timescale 1ns/1ps
module crc_step_engine
    import crc_unit_pkg::*;
(
    input  logic [WORD_W-1:0] crc_in,
    input  logic [WORD_W-1:0] poly,
    input  poly_size_e        size,
    input  logic [WORD_W-1:0] feed,
    input  logic [CNT_W-1:0]  feed_bits,
    output logic [WORD_W-1:0] crc_out
);

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] pmask;
    logic [WORD_W-1:0] c;
    logic [IDX_W-1:0]  top;
    logic              fb;

    always_comb begin
        mask  = size_mask(size);
        pmask = poly & mask;
        top   = IDX_W'(size_bits(size) - CNT_W'(1));
        c     = crc_in & mask;
        fb    = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (CNT_W'(i) < feed_bits) begin
                fb = c[top] ^ feed[WORD_W-1-i];
                c  = (c << 1) & mask;
                if (fb) c = c ^ pmask;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/crc_out_stage.sv
`timescale 1ns/1ps
module crc_out_stage
    import crc_unit_pkg::*;
(
    input  logic [WORD_W-1:0] crc_q,
    input  poly_size_e        size,
    input  logic              out_rev,
    output logic [WORD_W-1:0] result
);

    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] flipped;

    assign masked = crc_q & size_mask(size);

    for (genvar j = 0; j < WORD_W; j++) begin : g_flip
        assign flipped[j] = masked[WORD_W-1-j];
    end

    always_comb begin
        if (out_rev) result = flipped >> (CNT_W'(WORD_W) - size_bits(size));
        else         result = masked;
    end

endmodule

// File: rtl/crc_calc_unit.sv
`timescale 1ns/1ps
module crc_calc_unit
    import crc_unit_pkg::*;
#(
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    crc_cfg_t          cfg_q;
    logic [WORD_W-1:0] init_q;
    logic [WORD_W-1:0] poly_q;
    logic              reload_req;
    access_w_e         data_aw;
    logic [WORD_W-1:0] feed;
    logic [CNT_W-1:0]  feed_bits;
    logic [WORD_W-1:0] crc_mask;
    logic [WORD_W-1:0] crc_base;
    logic [WORD_W-1:0] crc_next;
    logic [WORD_W-1:0] crc_d;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] result;
    ctl_state_e        st_q;
    ctl_state_e        st_d;
    logic              reload_active;

    assign crc_mask      = size_mask(cfg_q.size);
    assign reload_active = (st_q == ST_RELOAD);

    crc_reg_bank #(
        .INIT_RST(INIT_RST),
        .POLY_RST(POLY_RST)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .reg_sel   (reg_sel_e'(bus_addr)),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .result    (result),
        .cfg_q     (cfg_q),
        .init_q    (init_q),
        .poly_q    (poly_q),
        .reload_req(reload_req),
        .data_aw   (data_aw),
        .rdata     (bus_rdata)
    );

    crc_in_shaper i_shape (
        .din      (bus_wdata),
        .aw       (data_aw),
        .mode     (cfg_q.in_rev),
        .feed     (feed),
        .feed_bits(feed_bits)
    );

    crc_step_engine i_step (
        .crc_in   (crc_base),
        .poly     (poly_q),
        .size     (cfg_q.size),
        .feed     (feed),
        .feed_bits(feed_bits),
        .crc_out  (crc_next)
    );

    crc_out_stage i_out (
        .crc_q  (crc_q),
        .size   (cfg_q.size),
        .out_rev(cfg_q.out_rev),
        .result (result)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:    st_d = reload_req ? ST_RELOAD : ST_RUN;
            ST_RELOAD: st_d = reload_req ? ST_RELOAD : ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        crc_base = crc_q;
        unique case (st_q)
            ST_RUN:    crc_base = crc_q;
            ST_RELOAD: crc_base = init_q & crc_mask;
        endcase
        crc_d = (data_aw != AW_NONE) ? crc_next : crc_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT_RST;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/crc_calc_unit_chk.sv
`timescale 1ns/1ps
module crc_calc_unit_chk #(
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic        reload_active,
    input logic [31:0] crc_q,
    input logic [31:0] init_q,
    input logic [31:0] poly_q,
    input logic [31:0] crc_mask
);

    logic any_wr;
    logic ctrl_reload_wr;
    logic odd_data_wr;

    assign any_wr         = bus_sel && bus_wr;
    assign ctrl_reload_wr = any_wr && (bus_addr == 2'd1) && bus_be[0] && bus_wdata[5];
    assign odd_data_wr    = any_wr && (bus_addr == 2'd0) &&
                            !(bus_be == 4'b0001 || bus_be == 4'b0011 || bus_be == 4'b1111);

    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (init_q == INIT_RST && poly_q == POLY_RST && crc_q == INIT_RST));

    p_enter_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reload_wr |=> reload_active);

    p_reload_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_active && !any_wr) |=> !reload_active);

    p_reload_loads_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_active && !any_wr) |=> (crc_q == $past(init_q & crc_mask)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_active && !any_wr) |=> $stable(crc_q));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(init_q) && $stable(poly_q)));

    p_odd_strobe_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_active && odd_data_wr) |=> $stable(crc_q));

endmodule

bind crc_calc_unit crc_calc_unit_chk #(
    .INIT_RST(INIT_RST),
    .POLY_RST(POLY_RST)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .reload_active(reload_active),
    .crc_q        (crc_q),
    .init_q       (init_q),
    .poly_q       (poly_q),
    .crc_mask     (crc_mask)
);

// File: tb/test_crc_calc_unit.sv
`timescale 1ns/1ps
module test_crc_calc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_be = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    crc_calc_unit i_crc_calc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_crc, m_init, m_poly;
    logic [1:0]  m_size, m_inrev;
    logic        m_outrev, m_reload;

    function automatic int m_bits(input logic [1:0] s);
        case (s)
            2'd0: return 32;
            2'd1: return 16;
            2'd2: return 8;
            default: return 7;
        endcase
    endfunction

    function automatic logic [31:0] m_mask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic int m_width(input logic [3:0] be);
        case (be)
            4'b0001: return 8;
            4'b0011: return 16;
            4'b1111: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_feed(input logic [31:0] crc, input logic [31:0] poly,
                                           input logic [1:0] sz, input logic [1:0] rv,
                                           input logic [31:0] d, input int w);
        int n, unit;
        logic [31:0] msk, x, c;
        logic fb;
        n    = m_bits(sz);
        msk  = m_mask(n);
        unit = (rv == 2'd1) ? 8 : (rv == 2'd2) ? 16 : (rv == 2'd3) ? 32 : 0;
        if (unit > w) unit = w;
        x = 32'd0;
        for (int k = 0; k < w; k++)
            x[k] = (unit == 0) ? d[k] : d[(k / unit) * unit + unit - 1 - (k % unit)];
        c = crc;
        for (int i = w - 1; i >= 0; i--) begin
            fb = c[n-1] ^ x[i];
            c  = (c << 1) & msk;
            if (fb) c = c ^ (poly & msk);
        end
        return c;
    endfunction

    function automatic logic [31:0] m_out(input logic [31:0] crc, input logic [1:0] sz, input logic orv);
        int n;
        logic [31:0] v, r;
        n = m_bits(sz);
        v = crc & m_mask(n);
        if (!orv) return v;
        r = 32'd0;
        for (int k = 0; k < n; k++) r[k] = v[n-1-k];
        return r;
    endfunction

    always @(posedge clk) begin
        logic [31:0] base, nxt;
        int w;
        if (!rst_n) begin
            m_crc = 32'hFFFF_FFFF; m_init = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
            m_size = 2'd0; m_inrev = 2'd0; m_outrev = 1'b0; m_reload = 1'b0;
        end else begin
            base     = m_reload ? (m_init & m_mask(m_bits(m_size))) : m_crc;
            m_reload = 1'b0;
            nxt      = base;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    2'd0: begin
                        w = m_width(bus_be);
                        if (w > 0) nxt = m_feed(base, m_poly, m_size, m_inrev, bus_wdata, w);
                    end
                    2'd1: if (bus_be[0]) begin
                        m_size = bus_wdata[1:0]; m_inrev = bus_wdata[3:2];
                        m_outrev = bus_wdata[4]; m_reload = bus_wdata[5];
                    end
                    2'd2: for (int l = 0; l < 4; l++) if (bus_be[l]) m_init[8*l +: 8] = bus_wdata[8*l +: 8];
                    default: for (int l = 0; l < 4; l++) if (bus_be[l]) m_poly[8*l +: 8] = bus_wdata[8*l +: 8];
                endcase
            end
            m_crc = nxt;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the data register (R2 R5 R6 R8 R9)
    always @(negedge clk) begin
        if (rst_n && !done && bus_addr == 2'd0)
            chk("R6 per-cycle data register", bus_rdata, m_out(m_crc, m_size, m_outrev));
    end

    task automatic drive_wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); #0.5;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    endtask

    task automatic go_idle();
        @(negedge clk); #0.5;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_be = 4'd0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        go_idle();
        @(negedge clk); #0.5;
        bus_sel = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        #0.5;
        bus_sel = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic feed_str(input string s);
        for (int i = 0; i < s.len(); i++) drive_wr(2'd0, 4'b0001, {24'd0, s[i]});
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        drive_wr(2'd1, 4'b0001, {24'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1;
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;

        rd(2'd2, v); chk("R1 init reset value", v, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R1 poly reset value", v, 32'h04C1_1DB7);
        rd(2'd1, v); chk("R1 ctrl reset value", v, 32'h0);
        rd(2'd0, v); chk("R1 data reset value", v, 32'hFFFF_FFFF);

        set_ctrl(8'h20); feed_str("123456789");
        rd(2'd0, v); chk("R3 default check value", v, 32'h0376_E6E7);

        set_ctrl(8'h20);
        drive_wr(2'd0, 4'b1111, 32'h3132_3334);
        drive_wr(2'd0, 4'b1111, 32'h3536_3738);
        drive_wr(2'd0, 4'b0001, 32'h39);
        rd(2'd0, v); chk("R2 word writes", v, 32'h0376_E6E7);

        set_ctrl(8'h20);
        drive_wr(2'd0, 4'b0011, 32'h3132); drive_wr(2'd0, 4'b0011, 32'h3334);
        drive_wr(2'd0, 4'b0011, 32'h3536); drive_wr(2'd0, 4'b0011, 32'h3738);
        drive_wr(2'd0, 4'b0001, 32'h39);
        rd(2'd0, v); chk("R2 half-word writes", v, 32'h0376_E6E7);

        set_ctrl(8'h20); feed_str("1234");
        rd(2'd1, v); feed_str("56789");
        rd(2'd0, v); chk("R6 continue without reload", v, 32'h0376_E6E7);

        set_ctrl(8'h30); feed_str("123456789");
        rd(2'd0, v); chk("R9 output reversal only", v, 32'hE767_6EC0);

        set_ctrl(8'h34); feed_str("123456789");
        rd(2'd0, v); chk("R4 reflected check value", ~v, 32'hCBF4_3926);
        set_ctrl(8'h34); drive_wr(2'd0, 4'b0001, 32'h0);
        rd(2'd0, v); chk("R4 reflected single zero byte", ~v, 32'hD202_EF8D);

        set_ctrl(8'h38);
        drive_wr(2'd0, 4'b0011, 32'h3231); drive_wr(2'd0, 4'b0011, 32'h3433);
        drive_wr(2'd0, 4'b0011, 32'h3635); drive_wr(2'd0, 4'b0011, 32'h3837);
        drive_wr(2'd0, 4'b0001, 32'h39);
        rd(2'd0, v); chk("R8 half-word reversal", ~v, 32'hCBF4_3926);
        set_ctrl(8'h3C);
        drive_wr(2'd0, 4'b1111, 32'h3433_3231); drive_wr(2'd0, 4'b1111, 32'h3837_3635);
        drive_wr(2'd0, 4'b0001, 32'h39);
        rd(2'd0, v); chk("R8 word reversal", ~v, 32'hCBF4_3926);

        set_ctrl(8'h20); drive_wr(2'd0, 4'b0001, 32'h31);
        rd(2'd0, v1);
        drive_wr(2'd0, 4'b0101, 32'hDEAD_BEEF); drive_wr(2'd0, 4'b1000, 32'h1234_5678);
        rd(2'd0, v); chk("R11 odd strobes ignored", v, v1);

        set_ctrl(8'h20); go_idle();
        rd(2'd0, v); chk("R5 reload to init", v, 32'hFFFF_FFFF);
        drive_wr(2'd0, 4'b0001, 32'h77);
        set_ctrl(8'h20); drive_wr(2'd0, 4'b0001, 32'h31);
        rd(2'd0, v); chk("R5 write right after reload", v, v1);

        drive_wr(2'd3, 4'b1111, 32'h0000_1021); set_ctrl(8'h21); feed_str("123456789");
        rd(2'd0, v); chk("R7 16-bit width", v, 32'h0000_29B1);
        drive_wr(2'd2, 4'b1111, 32'h0); drive_wr(2'd3, 4'b1111, 32'h07);
        set_ctrl(8'h22); feed_str("123456789");
        rd(2'd0, v); chk("R7 8-bit width", v, 32'h0000_00F4);
        drive_wr(2'd3, 4'b1111, 32'h09); set_ctrl(8'h23); feed_str("123456789");
        rd(2'd0, v); chk("R7 7-bit width", v, 32'h0000_0075);

        drive_wr(2'd2, 4'b0010, 32'hFFFF_ABFF);
        rd(2'd2, v); chk("R10 lane write to init", v, 32'h0000_AB00);
        set_ctrl(8'h20);
        rd(2'd0, v); chk("R10 32-bit reload of init", v, 32'h0000_AB00);
        set_ctrl(8'h22);
        rd(2'd0, v); chk("R10 8-bit masked reload", v, 32'h0);

        set_ctrl(8'h3D);
        rd(2'd1, v); chk("R12 control readback", v, 32'h0000_001D);

        for (int n = 0; n < 400; n++) begin
            logic [3:0] be;
            int pick;
            pick = $urandom % 10;
            be = (pick < 3) ? 4'b0001 : (pick < 5) ? 4'b0011 : (pick < 7) ? 4'b1111 : 4'($urandom);
            if (pick == 9) drive_wr(2'($urandom), be, $urandom);
            else drive_wr(2'd0, be, $urandom);
        end
        go_idle();
        rd(2'd0, v);
        chk("R2 random stream end value", v, m_out(m_crc, m_size, m_outrev));

        go_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule